// File: doc/BRIEF.md
# SD Card Clock Control Unit

This unit holds the clock-control register of an SD host controller and produces the card clock from the base clock. Software turns on the internal clock and then polls a read-only flag. The unit raises that flag a fixed number of base-clock cycles later. Only after the flag is up does setting the output-enable bit let the card clock run.

The card clock comes from an even divider set by an 8-bit divisor field. A divisor of zero passes the base clock straight through. The divisor and the output enable move from the register to the clock generator only while the card clock is low, so reprogramming never produces a shortened high or low pulse.

A reset-all request clears the register. It also raises a busy indication that the hardware drops by itself after a fixed number of cycles. This gives software the "bit clears when done" handshake.

Top module: `sdclk_unit`

## Requirements
- R1: Register layout: bits [15:8] hold the divisor, bit 2 is the card clock enable, bit 1 is the read-only stable flag and bit 0 is the internal clock enable. Bits 7:3 always read 0. A write updates the readback one cycle later, except for bit 1.
- R2: With a divisor D from 1 to 255 and the clock running, the card clock period is 2*D base-clock cycles.
- R3: With divisor 0 and the clock running, the card clock period equals the base-clock period.
- R4: The stable flag (bit 1) reads 0 for the first STABLE_CYCLES-1 clock edges after the edge that sets bit 0, and reads 1 after edge STABLE_CYCLES.
- R5: The stable flag reads 0 in the same cycle that bit 0 is written to 0. Writing 1 to bit 1 has no effect.
- R6: The card clock stays low, with no rising edge, unless bit 2, bit 0 and the stable flag are all set.
- R7: A change of divisor or enable takes effect only while the card clock is low. No high or low pulse is shorter than the smaller of the old and new half periods.
- R8: A reset-all request clears the register to 0 on the next edge. srst_busy_o then reads 1 for RST_CYCLES cycles and returns to 0 without software action.
- R9: Writes are ignored while srst_busy_o is 1. A reset-all request and a write in the same cycle leave the register at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | base clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| wr_en_i | input | 1 | register write strobe |
| wr_data_i | input | 16 | register write data |
| srst_i | input | 1 | reset-all request pulse |
| rd_data_o | output | 16 | register readback including the stable flag |
| srst_busy_o | output | 1 | reset-all in progress, cleared by hardware |
| sd_clk_o | output | 1 | card clock |

## Verification
A reset-all request and a register write can arrive in the same cycle. The bench drives both strobes on one falling edge, with write data that would set every field. The request must win: the readback is 0 on the next cycle and the busy flag is up. A write issued during the busy window must then leave the readback unchanged. A second collision happens when a new divisor lands while the card clock is mid-period. The bench reprograms the divisor with the clock running and judges the smallest high and low pulse widths it sees on the output.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int REG_W  = 16;
  localparam int DIV_W  = 8;
  localparam int DIV_LSB = 8;
  localparam int BIT_SD_EN  = 2;
  localparam int BIT_STABLE = 1;
  localparam int BIT_INT_EN = 0;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             sd_en;
    logic             int_en;
  } clk_cfg_t;
endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
  import sdclk_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             srst_i,
  output clk_cfg_t         cfg_o,
  output logic             busy_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  clk_cfg_t        cfg_q;
  logic            busy_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (srst_i) begin
      cfg_q  <= '0;
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(RST_CYCLES - 1)) busy_q <= 1'b0;
      else                              cnt_q  <= cnt_q + 1'b1;
    end else if (wr_en_i) begin
      cfg_q.div    <= wr_data_i[DIV_LSB +: DIV_W];
      cfg_q.sd_en  <= wr_data_i[BIT_SD_EN];
      cfg_q.int_en <= wr_data_i[BIT_INT_EN];
    end
  end

  assign cfg_o  = cfg_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/sdclk_stable_timer.sv
module sdclk_stable_timer #(
  parameter int STABLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_en_i,
  output logic stable_o
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!int_en_i) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!stable_q) begin
      if (cnt_q == CW'(STABLE_CYCLES - 1)) stable_q <= 1'b1;
      else                                 cnt_q    <= cnt_q + 1'b1;
    end
  end

  // drop with the enable, not one cycle later
  assign stable_o = stable_q & int_en_i;
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             en_i,
  output logic             sd_clk_o
);
  logic [DIV_W-1:0] act_div_q;
  logic             act_en_q;
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             byp_q;
  logic             run;
  logic             term;
  logic             cfg_chg;

  assign run     = act_en_q && (act_div_q != '0);
  assign term    = (cnt_q == act_div_q - 1'b1);
  assign cfg_chg = (div_i != act_div_q) || (en_i != act_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_div_q <= '0;
      act_en_q  <= 1'b0;
      cnt_q     <= '0;
      phase_q   <= 1'b0;
    end else if (cfg_chg && !phase_q) begin
      // output is low here; restart the low phase with the new setting
      act_div_q <= div_i;
      act_en_q  <= en_i;
      cnt_q     <= '0;
      phase_q   <= 1'b0;
    end else if (run) begin
      if (term) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end
  end

  // bypass select moves on the falling edge, while the base clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b0;
    else         byp_q <= act_en_q && (act_div_q == '0);
  end

  assign sd_clk_o = byp_q ? clk_i : phase_q;
endmodule

// File: rtl/sdclk_unit.sv
module sdclk_unit
  import sdclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 16,
  parameter int RST_CYCLES    = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        srst_i,
  output logic [15:0] rd_data_o,
  output logic        srst_busy_o,
  output logic        sd_clk_o
);
  clk_cfg_t cfg;
  logic     stable;
  logic     clk_run;

  sdclk_ctrl_reg #(.RST_CYCLES(RST_CYCLES)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .srst_i    (srst_i),
    .cfg_o     (cfg),
    .busy_o    (srst_busy_o)
  );

  sdclk_stable_timer #(.STABLE_CYCLES(STABLE_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .int_en_i (cfg.int_en),
    .stable_o (stable)
  );

  assign clk_run = cfg.sd_en & cfg.int_en & stable;

  sdclk_divider u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (cfg.div),
    .en_i     (clk_run),
    .sd_clk_o (sd_clk_o)
  );

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[DIV_LSB +: DIV_W]    = cfg.div;
    rd_data_o[BIT_SD_EN]           = cfg.sd_en;
    rd_data_o[BIT_STABLE]          = stable;
    rd_data_o[BIT_INT_EN]          = cfg.int_en;
  end
endmodule

// File: rtl/sdclk_unit_checker.sv
module sdclk_unit_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic        srst_i,
  input logic [15:0] rd_data_o,
  input logic        srst_busy_o
);
  a_r1_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !srst_i && !srst_busy_o) |=>
      (rd_data_o[15:8] == $past(wr_data_i[15:8])) && (rd_data_o[2] == $past(wr_data_i[2]))
      && (rd_data_o[0] == $past(wr_data_i[0])));

  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:3] == 5'b0);

  a_r5_stable_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[0] |-> !rd_data_o[1]);

  a_r4_no_early_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[1]) |-> $past(rd_data_o[0]));

  a_r8_reset_all_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (rd_data_o == 16'h0) && srst_busy_o);

  a_r9_busy_ignores_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_busy_o && wr_en_i && !srst_i) |=> $stable(rd_data_o[15:8]) && $stable(rd_data_o[2])
      && $stable(rd_data_o[0]));
endmodule

bind sdclk_unit sdclk_unit_checker u_sdclk_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .srst_i      (srst_i),
  .rd_data_o   (rd_data_o),
  .srst_busy_o (srst_busy_o)
);

// File: tb/sdclk_unit_bench.sv
`timescale 1ns/1ps
module sdclk_unit_bench;
  localparam int STAB = 16;
  localparam int RSTC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        srst = 1'b0;
  logic [15:0] rd_data;
  logic        busy;
  logic        sd_clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdclk_unit #(.STABLE_CYCLES(STAB), .RST_CYCLES(RSTC)) u_sdclk_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .srst_i(srst), .rd_data_o(rd_data), .srst_busy_o(busy), .sd_clk_o(sd_clk)
  );

  // card clock monitor
  int  rise_cnt = 0;
  real last_rise = 0.0, prev_rise = 0.0, last_fall = 0.0;
  real min_high = 1.0e9, min_low = 1.0e9;
  bit  seen_fall = 0;

  always @(posedge sd_clk) begin
    rise_cnt++;
    prev_rise = last_rise;
    last_rise = $realtime;
    if (seen_fall && ($realtime - last_fall) < min_low) min_low = $realtime - last_fall;
  end
  always @(negedge sd_clk) begin
    if (rise_cnt > 0 && ($realtime - last_rise) < min_high) min_high = $realtime - last_rise;
    last_fall = $realtime;
    seen_fall = 1;
  end

  task automatic chk_i(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_r(input string tag, input real act, input real exp);
    checks++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      fails++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mins();
    min_high = 1.0e9; min_low = 1.0e9; seen_fall = 0;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0;
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
    // reset state
    chk_i(rd_data == 16'h0, "R1 reset readback", rd_data, 0);
    chk_i(busy == 1'b0, "R8 reset busy", busy, 0);
    chk_i(rise_cnt == 0, "R6 reset no clock", rise_cnt, 0);

    // R1 layout, reserved bits and read-only stable bit (R5)
    wr(16'hA5FA);
    chk_i(rd_data == 16'hA500, "R1 readback fields", rd_data, 16'hA500);
    wr(16'h0000);

    // R6: card enable without internal enable: no edges
    r0 = rise_cnt;
    wr(16'h0204);
    cycles(40);
    chk_i(rise_cnt == r0, "R6 no int enable", rise_cnt - r0, 0);
    wr(16'h0000);

    // R4 stable timing, R6 no clock before stable
    r0 = rise_cnt;
    wr(16'h0105);
    cycles(STAB - 1);
    chk_i(rd_data[1] == 1'b0, "R4 stable early", rd_data[1], 0);
    chk_i(rise_cnt == r0, "R6 no clock before stable", rise_cnt - r0, 0);
    cycles(1);
    chk_i(rd_data[1] == 1'b1, "R4 stable on time", rd_data[1], 1);

    // R5 clears in the write cycle
    @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h0104;
    @(posedge clk);
    #1;
    chk_i(rd_data[1] == 1'b0, "R5 stable drop", rd_data[1], 0);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    r0 = rise_cnt;
    cycles(20);
    chk_i(rise_cnt == r0, "R6 stops when disabled", rise_cnt - r0, 0);

    // R2/R3 divisor sweep
    for (int d = 0; d <= 257; d++) begin
      int dv;
      real exp_p;
      dv = (d <= 32) ? d : ((d == 33) ? 127 : 255);
      if (d > 34) break;
      wr(16'h0000);
      wr({dv[7:0], 8'h01});
      cycles(STAB + 2);
      wr({dv[7:0], 8'h05});
      r0 = rise_cnt;
      cycles(8 * dv + 10);
      exp_p = (dv == 0) ? 5.0 : 10.0 * dv;
      chk_i(rise_cnt > r0 + 1, (dv == 0) ? "R3 running" : "R2 running", rise_cnt - r0, 2);
      chk_r((dv == 0) ? "R3 bypass period" : "R2 divided period", last_rise - prev_rise, exp_p);
    end

    // R7 reprogramming on the fly
    wr(16'h0305);
    cycles(40);
    clear_mins();
    wr(16'h0105);
    cycles(13);
    wr(16'h0205);
    cycles(17);
    wr(16'h0105);
    cycles(30);
    chk_r("R7 min high", (min_high < 5.0) ? min_high : 5.0, 5.0);
    chk_r("R7 min low", (min_low < 5.0) ? min_low : 5.0, 5.0);
    clear_mins();
    wr(16'h0005);
    cycles(20);
    wr(16'h0305);
    cycles(40);
    chk_r("R7 bypass min high", (min_high < 2.5) ? min_high : 2.5, 2.5);
    chk_r("R7 bypass min low", (min_low < 2.5) ? min_low : 2.5, 2.5);

    // R8 reset-all, R9 collision with write
    @(negedge clk);
    srst = 1'b1; wr_en = 1'b1; wr_data = 16'hFFFF;
    @(negedge clk);
    srst = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk_i(rd_data == 16'h0, "R9 reset wins over write", rd_data, 0);
    chk_i(busy == 1'b1, "R8 busy set", busy, 1);
    wr(16'h4401);
    chk_i(rd_data == 16'h0, "R9 write ignored when busy", rd_data, 0);
    cycles(RSTC - 3);
    chk_i(busy == 1'b1, "R8 busy held", busy, 1);
    cycles(1);
    chk_i(busy == 1'b0, "R8 busy self clears", busy, 0);
    r0 = rise_cnt;
    cycles(20);
    chk_i(rise_cnt == r0, "R8 clock stopped", rise_cnt - r0, 0);
    wr(16'h4401);
    chk_i(rd_data == 16'h4400 | 16'h0001, "R1 write after busy", rd_data, 16'h4401);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule